// File: doc/BRIEF.md
# Keyed Watchdog Timer Controller

This block watches that software keeps running. It counts clock cycles. If software does not service it before the selected interval ends, it emits one timeout pulse. A mode setting decides whether that pulse is a non-maskable interrupt request or a system reset request. An interrupt request always carries exception code 0x0020, which makes the processor branch to handler address 0x00000020.

The counter runs from the moment reset is released. Until software changes it, the timeout action is reset and the interval is the longest one. Software services the counter in one of two ways: by writing the key byte 0xAC to the key register, or by writing 1 to the run bit. The run bit is meant to be written just before the processor enters its low-power stop state. While the stop input is high, the counter is frozen.

The mode register takes exactly one write per reset. That single write is also the only way to switch the watchdog off. The switch-off request works only if the counter has been serviced since reset or since the last timeout. Writing any other byte to the key register is treated as a failure and triggers the timeout action at once.

Top module: `wdog_ctrl`

## Requirements
- R1: During reset both request outputs are 0 and the code output is 0. After reset release the counter runs with the reset action and interval select 7. With no service, a reset request pulse appears 2^(TAP_LSB+7) cycles after release and again every such interval.
- R2: A write of 0xAC to address 1 restarts the count from zero while running. The next timeout comes exactly one interval after the capturing clock edge.
- R3: A write of any other byte to address 1 while running produces the timeout pulse in the cycle right after the capturing edge, and restarts the count from zero.
- R4: A write to address 2 with bit 0 = 1 restarts the count from zero while running. With bit 0 = 0 it has no effect.
- R5: While the stop input is high, the count holds. A timeout is delayed by exactly the number of stopped cycles.
- R6: Mode register (address 0) bits [2:0] select an interval of 2^(TAP_LSB+sel) cycles (TAP_LSB default 10, so 2^10 to 2^17). Bit 3 = 1 selects the interrupt action; bit 3 = 0 selects the reset action. A mode write does not restart the count.
- R7: Whenever the interrupt request is high, the code output reads 0x0020.
- R8: Only the first mode write after reset is accepted. Later mode writes change nothing.
- R9: Mode bit 4 = 1 stops the watchdog only if a service (R2 or R4) occurred since reset or since the last timeout. Otherwise bit 4 is ignored and the other fields of that write still apply.
- R10: Once stopped, the watchdog emits no further pulses and ignores key and run writes until reset.
- R11: Each timeout gives exactly one single-cycle pulse on exactly one of the two request outputs, never both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address: 0 mode, 1 key, 2 run |
| wr_data | input | 8 | Write data |
| stop_i | input | 1 | Stop state; freezes the count |
| nmi_req_o | output | 1 | Non-maskable interrupt request pulse |
| nmi_code_o | output | 16 | Exception code, 0x0020 during an interrupt request |
| rst_req_o | output | 1 | System reset request pulse |

## Verification
The following are checked on every cycle:
- the two request outputs are never high together;
- the interrupt request always carries its code;
- a bad key always produces an immediate pulse;
- key and run-bit service always zero the count;
- the count holds while stopped;
- the mode fields freeze once written;
- a stopped watchdog stays silent.

Only the bench scenarios can show the following:
- the exact timeout distances for different interval selections;
- the default reset-mode start after release;
- the one-write lock on the mode register;
- the conditional acceptance of the switch-off request.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    localparam logic [7:0]  WD_KEY      = 8'hAC;
    localparam logic [15:0] WD_NMI_CODE = 16'h0020;

    localparam int MODE_NMI_BIT  = 3;
    localparam int MODE_HALT_BIT = 4;

    typedef enum logic [1:0] {
        REG_MODE = 2'd0,
        REG_KEY  = 2'd1,
        REG_RUN  = 2'd2
    } reg_sel_e;

    typedef struct packed {
        logic mode_wr;
        logic key_ok;
        logic key_bad;
        logic run_clr;
    } bus_evt_t;

endpackage

// File: rtl/wdog_regif.sv
module wdog_regif
    import wdog_pkg::*;
#(
    parameter int SEL_W = 3
) (
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [7:0]       wr_data,
    output bus_evt_t         evt,
    output logic [SEL_W-1:0] mode_sel,
    output logic             mode_nmi,
    output logic             mode_halt
);

    logic unused_hi;
    assign unused_hi = ^wr_data[7:5];

    assign mode_sel  = wr_data[SEL_W-1:0];
    assign mode_nmi  = wr_data[MODE_NMI_BIT];
    assign mode_halt = wr_data[MODE_HALT_BIT];

    always_comb begin
        evt = '0;
        if (wr_en) begin
            case (wr_addr)
                REG_MODE: evt.mode_wr = 1'b1;
                REG_KEY: begin
                    evt.key_ok  = (wr_data == WD_KEY);
                    evt.key_bad = (wr_data != WD_KEY);
                end
                REG_RUN:  evt.run_clr = wr_data[0];
                default:  evt = '0;
            endcase
        end
    end

endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
    parameter int TAP_LSB  = 10,
    parameter int NUM_TAPS = 8,
    parameter int SEL_W    = 3,
    parameter int CNT_W    = TAP_LSB + NUM_TAPS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             count_en,
    input  logic             clear,
    input  logic [SEL_W-1:0] tap_sel,
    output logic             ovf,
    output logic [CNT_W-1:0] cnt
);

    logic [CNT_W:0]   lim [NUM_TAPS];
    logic [CNT_W:0]   nxt;
    logic [CNT_W-1:0] cnt_d, cnt_q;

    for (genvar g = 0; g < NUM_TAPS; g++) begin : g_tap
        assign lim[g] = (CNT_W+1)'(1) << (TAP_LSB + g);
    end

    assign nxt = {1'b0, cnt_q} + (CNT_W+1)'(1);
    assign ovf = count_en && !clear && (nxt >= lim[tap_sel]);
    assign cnt = cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clear || ovf) begin
            cnt_d = '0;
        end else if (count_en) begin
            cnt_d = nxt[CNT_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/wdog_ctrl.sv
module wdog_ctrl
    import wdog_pkg::*;
#(
    parameter int TAP_LSB  = 10,
    parameter int NUM_TAPS = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [1:0]  wr_addr,
    input  logic [7:0]  wr_data,
    input  logic        stop_i,
    output logic        nmi_req_o,
    output logic [15:0] nmi_code_o,
    output logic        rst_req_o
);

    localparam int SEL_W = $clog2(NUM_TAPS);
    localparam int CNT_W = TAP_LSB + NUM_TAPS;

    typedef struct packed {
        logic             locked;
        logic [SEL_W-1:0] sel;
        logic             nmi_mode;
        logic             running;
        logic             cleared;
        logic             nmi;
        logic             rst;
    } ctl_t;

    ctl_t             st_d, st_q;
    bus_evt_t         evt;
    logic [SEL_W-1:0] mode_sel;
    logic             mode_nmi, mode_halt;
    logic             svc_clear, force_to, cnt_clear, count_en, ovf, timeout;
    logic [CNT_W-1:0] cnt_w;
    logic             running_w;
    logic             locked_w;
    logic [SEL_W-1:0] sel_w;

    wdog_regif #(.SEL_W(SEL_W)) u_regif (
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .evt       (evt),
        .mode_sel  (mode_sel),
        .mode_nmi  (mode_nmi),
        .mode_halt (mode_halt)
    );

    assign svc_clear = st_q.running && (evt.key_ok || evt.run_clr);
    assign force_to  = st_q.running && evt.key_bad;
    assign cnt_clear = svc_clear || force_to;
    assign count_en  = st_q.running && !stop_i;

    wdog_counter #(
        .TAP_LSB  (TAP_LSB),
        .NUM_TAPS (NUM_TAPS),
        .SEL_W    (SEL_W),
        .CNT_W    (CNT_W)
    ) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .count_en (count_en),
        .clear    (cnt_clear),
        .tap_sel  (st_q.sel),
        .ovf      (ovf),
        .cnt      (cnt_w)
    );

    assign timeout = force_to || ovf;

    always_comb begin
        st_d     = st_q;
        st_d.nmi = timeout && st_q.nmi_mode;
        st_d.rst = timeout && !st_q.nmi_mode;
        if (timeout) begin
            st_d.cleared = 1'b0;
        end else if (svc_clear) begin
            st_d.cleared = 1'b1;
        end
        if (evt.mode_wr && !st_q.locked) begin
            st_d.locked   = 1'b1;
            st_d.sel      = mode_sel;
            st_d.nmi_mode = mode_nmi;
            if (mode_halt && st_q.cleared) begin
                st_d.running = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q          <= '0;
            st_q.sel      <= SEL_W'(NUM_TAPS - 1);
            st_q.running  <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign nmi_req_o  = st_q.nmi;
    assign rst_req_o  = st_q.rst;
    assign nmi_code_o = st_q.nmi ? WD_NMI_CODE : 16'h0000;
    assign running_w  = st_q.running;
    assign locked_w   = st_q.locked;
    assign sel_w      = st_q.sel;

endmodule

// File: rtl/wdog_ctrl_chk.sv
module wdog_ctrl_chk
    import wdog_pkg::*;
#(
    parameter int SEL_W = 3,
    parameter int CNT_W = 18
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [1:0]       wr_addr,
    input logic [7:0]       wr_data,
    input logic             stop_i,
    input logic             nmi_req_o,
    input logic [15:0]      nmi_code_o,
    input logic             rst_req_o,
    input logic             running,
    input logic             locked,
    input logic [SEL_W-1:0] sel,
    input logic [CNT_W-1:0] cnt
);

    AST_KEY_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        running && wr_en && wr_addr == REG_KEY && wr_data == WD_KEY |=> cnt == '0); // R2

    AST_BAD_KEY_FIRES: assert property (@(posedge clk) disable iff (!rst_n)
        running && wr_en && wr_addr == REG_KEY && wr_data != WD_KEY |=> nmi_req_o || rst_req_o); // R3

    AST_RUN_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        running && wr_en && wr_addr == REG_RUN && wr_data[0] |=> cnt == '0); // R4

    AST_STOP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        stop_i && !wr_en |=> $stable(cnt)); // R5

    AST_NMI_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_req_o |-> nmi_code_o == WD_NMI_CODE); // R7

    AST_MODE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> $stable(sel)); // R8

    AST_HALTED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !running |=> !nmi_req_o && !rst_req_o); // R10

    AST_ONE_ACTION: assert property (@(posedge clk) disable iff (!rst_n)
        !(nmi_req_o && rst_req_o)); // R11

endmodule

bind wdog_ctrl wdog_ctrl_chk #(.SEL_W(SEL_W), .CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .stop_i     (stop_i),
    .nmi_req_o  (nmi_req_o),
    .nmi_code_o (nmi_code_o),
    .rst_req_o  (rst_req_o),
    .running    (running_w),
    .locked     (locked_w),
    .sel        (sel_w),
    .cnt        (cnt_w)
);

// File: tb/tb_wdog_ctrl.sv
module tb_wdog_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int TAP_LSB    = 4;
    localparam int NUM_TAPS   = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = 2'd0;
    logic [7:0]  wr_data = 8'd0;
    logic        stop_i = 1'b0;
    logic        nmi_req_o, rst_req_o;
    logic [15:0] nmi_code_o;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;

    typedef struct {
        bit    is_nmi;
        int    at;
        string req;
    } exp_t;

    exp_t sb_q[$];
    exp_t mon_e;

    wdog_ctrl #(.TAP_LSB(TAP_LSB), .NUM_TAPS(NUM_TAPS)) dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .stop_i     (stop_i),
        .nmi_req_o  (nmi_req_o),
        .nmi_code_o (nmi_code_o),
        .rst_req_o  (rst_req_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(bit ok, string req, string what, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int ivl(int sel);
        return 1 << (TAP_LSB + sel);
    endfunction

    task automatic expect_evt(bit is_nmi, int at, string req);
        exp_t e;
        e.is_nmi = is_nmi;
        e.at     = at;
        e.req    = req;
        sb_q.push_back(e);
    endtask

    // monitor: pops the scoreboard on every observed request pulse
    always @(negedge clk) begin
        if (rst_n && (nmi_req_o || rst_req_o)) begin
            chk(!(nmi_req_o && rst_req_o), "R11", "both requests high", 1, 0);
            if (sb_q.size() == 0) begin
                chk(1'b0, "R11", "unexpected pulse at cycle", cyc, -1);
            end else begin
                mon_e = sb_q.pop_front();
                chk(nmi_req_o == mon_e.is_nmi, mon_e.req, "pulse is nmi",
                    int'(nmi_req_o), int'(mon_e.is_nmi));
                chk(cyc == mon_e.at, mon_e.req, "pulse cycle", cyc, mon_e.at);
            end
            if (nmi_req_o) begin
                chk(nmi_code_o == 16'h0020, "R7", "nmi code", int'(nmi_code_o), 32);
            end
        end
    end

    task automatic bus_wr(logic [1:0] a, logic [7:0] d, output int edge_no);
        wr_en   = 1'b1;
        wr_addr = a;
        wr_data = d;
        edge_no = cyc + 1;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic wait_until(int c);
        while (cyc < c) @(negedge clk);
    endtask

    task automatic do_reset(output int rel);
        @(negedge clk);
        rst_n  = 1'b0;
        wr_en  = 1'b0;
        stop_i = 1'b0;
        repeat (3) @(negedge clk);
        chk(!nmi_req_o && !rst_req_o && nmi_code_o == 16'h0, "R1",
            "outputs in reset", int'({nmi_req_o, rst_req_o}), 0);
        sb_q.delete();
        rst_n = 1'b1;
        rel   = cyc;
    endtask

    task automatic drained(string req, int upto);
        wait_until(upto);
        chk(sb_q.size() == 0, req, "pending expected pulses", sb_q.size(), 0);
    endtask

    initial begin
        int r, e, ek, eb, er;

        // R1: default start, reset action, longest interval
        do_reset(r);
        expect_evt(1'b0, r + ivl(7), "R1");
        expect_evt(1'b0, r + 2*ivl(7), "R1");
        drained("R1", r + 2*ivl(7) + 8);

        // R6 interrupt action, interval 0; R8 second mode write ignored
        do_reset(r);
        bus_wr(2'd0, 8'h08, e);
        ek = cyc + 1;
        expect_evt(1'b1, ek + ivl(0), "R6");
        expect_evt(1'b1, ek + 2*ivl(0), "R2");
        expect_evt(1'b1, ek + 3*ivl(0), "R8");
        bus_wr(2'd1, 8'hAC, ek);
        bus_wr(2'd0, 8'h03, e);
        drained("R8", ek + 3*ivl(0) + 10);

        // R3 bad key fires at once, count restarts; R6 reset action interval 1
        do_reset(r);
        bus_wr(2'd0, 8'h01, e);
        bus_wr(2'd1, 8'hAC, ek);
        repeat (10) @(negedge clk);
        eb = cyc + 1;
        expect_evt(1'b0, eb, "R3");
        expect_evt(1'b0, eb + ivl(1), "R6");
        bus_wr(2'd1, 8'h55, eb);
        drained("R3", eb + ivl(1) + 8);

        // R4 run bit with bit0 = 0 does nothing, bit0 = 1 restarts
        do_reset(r);
        bus_wr(2'd0, 8'h08, e);
        ek = cyc + 1;
        expect_evt(1'b1, ek + ivl(0), "R4");
        bus_wr(2'd1, 8'hAC, ek);
        repeat (3) @(negedge clk);
        bus_wr(2'd2, 8'hFE, e);
        wait_until(ek + ivl(0) + 4);
        er = cyc + 1;
        expect_evt(1'b1, er + ivl(0), "R4");
        bus_wr(2'd2, 8'h01, er);
        drained("R4", er + ivl(0) + 8);

        // R5 stop freezes the count for 20 cycles
        do_reset(r);
        bus_wr(2'd0, 8'h09, e);
        ek = cyc + 1;
        expect_evt(1'b1, ek + ivl(1) + 20, "R5");
        bus_wr(2'd1, 8'hAC, ek);
        repeat (5) @(negedge clk);
        stop_i = 1'b1;
        repeat (20) @(negedge clk);
        stop_i = 1'b0;
        drained("R5", ek + ivl(1) + 30);

        // R9 halt request without prior service is ignored, other fields apply
        do_reset(r);
        bus_wr(2'd0, 8'h18, e);
        ek = cyc + 1;
        expect_evt(1'b1, ek + ivl(0), "R9");
        expect_evt(1'b1, ek + 2*ivl(0), "R9");
        bus_wr(2'd1, 8'hAC, ek);
        drained("R9", ek + 2*ivl(0) + 8);

        // R9 halt after service is accepted; R10 stopped block stays silent
        do_reset(r);
        bus_wr(2'd1, 8'hAC, ek);
        bus_wr(2'd0, 8'h18, e);
        repeat (2) @(negedge clk);
        bus_wr(2'd1, 8'h00, e);
        bus_wr(2'd2, 8'h01, e);
        repeat (300) @(negedge clk);
        chk(!nmi_req_o && !rst_req_o, "R10", "request while stopped",
            int'({nmi_req_o, rst_req_o}), 0);
        drained("R10", cyc);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (60000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: run hung, actual=%0d expected=done", cyc);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule